// File: doc/BRIEF.md
# I2C Read-Only Slave with Host-Paced Clock Stretching

This block is the slave end of an I2C bus that only serves reads. It watches the bus for a Start condition, collects the 7-bit address and the direction bit, and acknowledges only when the address equals its configured address and the direction bit asks for a read. From then on the local host sets the pace. After the address byte, and after every data byte that the master acknowledges, the block holds SCL low. The hold ends only after the host has written the next byte into the data buffer and then pulsed a release input.

Bytes go out MSB first. SDA changes only while SCL is low. The master's acknowledge bit decides what follows: an ACK leads to another stretch for the next byte, and a NACK ends the transfer. The host sees a data buffer with a buffer-full flag, a read/write status bit and a sticky per-byte interrupt flag that only it can clear. The bus lines are open-drain. The block drives only pull-low enables and never a high level. SCL and SDA are oversampled by the system clock through synchronizers.

Top module: `i2c_rd_slave`

## Requirements
- R1: After reset the block pulls neither line low, and the buffer-full flag, the read/write status bit, the interrupt flag and the buffer contents are all zero.
- R2: When an address byte equals {own address, 1} (direction bit last, 1 means read), the block pulls SDA low during the ninth clock, sets the read/write status bit and places the received address byte in the data buffer.
- R3: An address byte with a different address, or with the direction bit 0, gets no acknowledge (SDA stays high on the ninth clock), raises no interrupt, leaves the status bit at 0 and causes no clock stretching.
- R4: The interrupt flag is set on the falling edge of the ninth SCL pulse of each served byte (the address byte and every data byte) and stays set until the host pulses the clear input.
- R5: After the falling edge of the ninth clock of a matched address byte, SCL is held low until a release pulse arrives while the buffer is full; a release pulse given before any buffer write is ignored.
- R6: A buffer write is accepted only while the block is stretching SCL. An accepted write sets the buffer-full flag and shows the byte on the buffer read port. A write at any other time changes neither the flag nor the buffer.
- R7: A released data byte appears on SDA MSB first, one bit per SCL pulse, and SDA does not change while SCL is high.
- R8: The buffer-full flag clears once the eighth data bit has been shifted out. If the master acknowledges (SDA low at the ninth rising edge), SCL is stretched again after the ninth falling edge.
- R9: If the master does not acknowledge, after the ninth clock the block releases both lines, clears the status bit and the buffer-full flag, and serves no further byte until a new Start condition.
- R10: A Stop condition (SDA rising while SCL is high) at any point releases both lines, returns the block to idle and clears the buffer-full flag and the status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_pull_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge or data 0) |
| own_addr_i | input | 7 | Configured slave address |
| buf_we_i | input | 1 | Host write strobe for the data buffer |
| buf_wdata_i | input | 8 | Host write data |
| release_i | input | 1 | Host pulse that ends the clock stretch |
| irq_clr_i | input | 1 | Host pulse that clears the interrupt flag |
| buf_rdata_o | output | 8 | Data buffer contents |
| buf_full_o | output | 1 | Buffer written and not yet fully sent |
| rw_o | output | 1 | Read/write status: a read is in progress |
| irq_o | output | 1 | Sticky per-byte interrupt flag |

## Verification
The assertions assume a well-behaved master. It changes SDA only while SCL is low, except to make a Start or Stop condition. It keeps each SCL phase several system clocks long, and it waits for SCL to read high before it counts a clock as started, so a stretch really pauses it. The bench master models the bus as wired-AND. It holds each SCL phase for eight system clocks, sets SDA in the middle of the low phase, and spins on the sensed SCL level before each high phase. The host strobes are single-cycle pulses driven between clock edges, with a write always at least one cycle before its release.

// File: rtl/i2c_rd_pkg.sv
// Package: shared types for the I2C read-only slave.
// Assumes: nothing beyond IEEE 1800-2017.
package i2c_rd_pkg;

    // Protocol phase of the slave controller.
    typedef enum logic [2:0] {
        PH_IDLE,     // waiting for a Start condition
        PH_ADDR,     // collecting address and direction bits
        PH_ACK_ADDR, // pulling SDA low for the address acknowledge
        PH_HOLD,     // stretching SCL until the host releases
        PH_SEND,     // shifting a data byte out on SDA
        PH_ACK_HOST  // sampling the master's acknowledge
    } slv_phase_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings SCL and SDA into the clock domain and flags SCL edges and
// Start/Stop conditions as one-cycle pulses.
// Assumes: the system clock runs at least 8x the SCL rate; STAGES >= 2.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_s;
    logic              scl_d;
    logic              sda_d;

    // Synchronizer chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // Edge and bus-condition decode on synchronized levels.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/i2c_host_regs.sv
// Module: i2c_host_regs
// Host-visible state: data buffer, buffer-full flag, read/write status,
// sticky interrupt flag, and qualification of host write/release strobes.
// Assumes: strobes are single-cycle; hold_i is high only while SCL is stretched.
module i2c_host_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_we_i,
    input  logic [DATA_W-1:0] buf_wdata_i,
    input  logic              release_i,
    input  logic              irq_clr_i,
    input  logic              hold_i,
    input  logic              addr_load_i,
    input  logic [DATA_W-1:0] addr_byte_i,
    input  logic              byte_done_i,
    input  logic              clr_status_i,
    input  logic              start_i,
    input  logic              set_irq_i,
    output logic [DATA_W-1:0] buf_q,
    output logic              buf_full,
    output logic              rw_q,
    output logic              irq_q,
    output logic              wr_ok,
    output logic              release_ok
);
    // Strobe qualification: writes only during a stretch, release only once full.
    always_comb begin
        wr_ok      = buf_we_i & hold_i;
        release_ok = release_i & hold_i & buf_full & ~buf_we_i;
    end

    // Data buffer: address byte on a match, host byte on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)           buf_q <= '0;
        else if (addr_load_i) buf_q <= addr_byte_i;
        else if (wr_ok)       buf_q <= buf_wdata_i;
    end

    // Buffer-full flag: set by a write, cleared when sent or on bus end.
    always_ff @(posedge clk) begin
        if (!rst_n)                           buf_full <= 1'b0;
        else if (clr_status_i | byte_done_i)  buf_full <= 1'b0;
        else if (wr_ok)                       buf_full <= 1'b1;
    end

    // Read/write status: set on a matched read, cleared on new Start or end.
    always_ff @(posedge clk) begin
        if (!rst_n)                     rw_q <= 1'b0;
        else if (clr_status_i | start_i) rw_q <= 1'b0;
        else if (addr_load_i)           rw_q <= 1'b1;
    end

    // Interrupt flag: set per byte, cleared only by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq_q <= 1'b0;
        else if (set_irq_i) irq_q <= 1'b1;
        else if (irq_clr_i) irq_q <= 1'b0;
    end

    assert_irq_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_clr_i) |=> irq_q);

    assert_full_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_full) |-> $past(buf_we_i && hold_i));

endmodule

// File: rtl/i2c_rd_fsm.sv
// Module: i2c_rd_fsm
// Protocol controller: address capture and compare, address acknowledge,
// clock stretch, MSB-first data shifting and master-acknowledge handling.
// Assumes: edge/condition pulses come from i2c_line_sync; DATA_W = ADDR_W + 1.
module i2c_rd_fsm
    import i2c_rd_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              wr_ok,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              release_ok,
    input  logic              buf_full,
    output logic              scl_low_o,
    output logic              sda_low_o,
    output logic              hold_o,
    output logic              addr_load_o,
    output logic [DATA_W-1:0] addr_byte_o,
    output logic              byte_done_o,
    output logic              clr_status_o,
    output logic              start_o,
    output logic              set_irq_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] FULL_BYTE = CNT_W'(DATA_W);

    slv_phase_t        phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic              host_ack;
    logic              addr_hit;

    // Address compare: upper bits against own address, last bit must request a read.
    always_comb begin
        addr_hit = (shreg[DATA_W-1 -: ADDR_W] == own_addr) & shreg[0];
    end

    // One-cycle event pulses toward the host register block.
    always_comb begin
        addr_load_o  = 1'b0;
        byte_done_o  = 1'b0;
        clr_status_o = 1'b0;
        start_o      = 1'b0;
        set_irq_o    = 1'b0;
        if (stop_det) begin
            clr_status_o = 1'b1;
        end else if (start_det) begin
            start_o = 1'b1;
        end else begin
            case (phase)
                PH_ADDR:     addr_load_o = scl_fall & (bit_cnt == FULL_BYTE) & addr_hit;
                PH_ACK_ADDR: set_irq_o   = scl_fall;
                PH_SEND:     byte_done_o = scl_fall & (bit_cnt == LAST_BIT);
                PH_ACK_HOST: begin
                    set_irq_o    = scl_fall;
                    clr_status_o = scl_fall & ~host_ack;
                end
                default: ;
            endcase
        end
    end

    // Phase sequencing, bit counting and the shared shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            host_ack <= 1'b0;
        end else if (stop_det) begin
            phase <= PH_IDLE;
        end else if (start_det) begin
            phase   <= PH_ADDR;
            bit_cnt <= '0;
        end else begin
            case (phase)
                PH_ADDR: begin
                    if (scl_rise && bit_cnt < FULL_BYTE) begin
                        shreg   <= {shreg[DATA_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && bit_cnt == FULL_BYTE) begin
                        phase <= addr_hit ? PH_ACK_ADDR : PH_IDLE;
                    end
                end
                PH_ACK_ADDR: begin
                    if (scl_fall) phase <= PH_HOLD;
                end
                PH_HOLD: begin
                    if (wr_ok) shreg <= wr_data;
                    if (release_ok) begin
                        phase   <= PH_SEND;
                        bit_cnt <= '0;
                    end
                end
                PH_SEND: begin
                    if (scl_fall) begin
                        shreg   <= {shreg[DATA_W-2:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == LAST_BIT) phase <= PH_ACK_HOST;
                    end
                end
                PH_ACK_HOST: begin
                    if (scl_rise) host_ack <= ~sda_s;
                    if (scl_fall) phase <= host_ack ? PH_HOLD : PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Open-drain enables: D7 is presented during the stretch once the buffer is full.
    always_comb begin
        hold_o      = (phase == PH_HOLD);
        scl_low_o   = hold_o;
        addr_byte_o = shreg;
        sda_low_o   = (phase == PH_ACK_ADDR)
                    | ((phase == PH_SEND) & ~shreg[DATA_W-1])
                    | (hold_o & buf_full & ~shreg[DATA_W-1]);
    end

    assert_release_only_by_host_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_low_o) && !$past(stop_det)) |-> $past(release_ok));

    assert_sda_moves_after_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SEND && $past(phase) == PH_SEND && !$stable(sda_low_o)) |-> $past(scl_fall));

    assert_end_frees_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_status_o && !stop_det) |=> (!scl_low_o && !sda_low_o));

    assert_stop_frees_lines_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!scl_low_o && !sda_low_o));

endmodule

// File: rtl/i2c_rd_slave.sv
// Module: i2c_rd_slave (top)
// I2C slave that serves reads to its 7-bit address, stretching SCL
// after each served byte until the host supplies the next one.
// Assumes: open-drain bus sensed on scl_i/sda_i; system clock >= 8x SCL.
module i2c_rd_slave #(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                scl_pull_o,
    output logic                sda_pull_o,
    input  logic [ADDR_W-1:0]   own_addr_i,
    input  logic                buf_we_i,
    input  logic [ADDR_W:0]     buf_wdata_i,
    input  logic                release_i,
    input  logic                irq_clr_i,
    output logic [ADDR_W:0]     buf_rdata_o,
    output logic                buf_full_o,
    output logic                rw_o,
    output logic                irq_o
);
    localparam int DATA_W = ADDR_W + 1;

    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_ok, release_ok, hold, addr_load, byte_done;
    logic              clr_status, start_evt, set_irq;
    logic [DATA_W-1:0] addr_byte;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_host_regs #(.DATA_W(DATA_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .buf_we_i     (buf_we_i),
        .buf_wdata_i  (buf_wdata_i),
        .release_i    (release_i),
        .irq_clr_i    (irq_clr_i),
        .hold_i       (hold),
        .addr_load_i  (addr_load),
        .addr_byte_i  (addr_byte),
        .byte_done_i  (byte_done),
        .clr_status_i (clr_status),
        .start_i      (start_evt),
        .set_irq_i    (set_irq),
        .buf_q        (buf_rdata_o),
        .buf_full     (buf_full_o),
        .rw_q         (rw_o),
        .irq_q        (irq_o),
        .wr_ok        (wr_ok),
        .release_ok   (release_ok)
    );

    i2c_rd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sda_s        (sda_s),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .own_addr     (own_addr_i),
        .wr_ok        (wr_ok),
        .wr_data      (buf_wdata_i),
        .release_ok   (release_ok),
        .buf_full     (buf_full_o),
        .scl_low_o    (scl_pull_o),
        .sda_low_o    (sda_pull_o),
        .hold_o       (hold),
        .addr_load_o  (addr_load),
        .addr_byte_o  (addr_byte),
        .byte_done_o  (byte_done),
        .clr_status_o (clr_status),
        .start_o      (start_evt),
        .set_irq_o    (set_irq)
    );

endmodule

// File: tb/i2c_rd_slave_tb.sv
// Bench for i2c_rd_slave: wired-AND bus model, bit-level master, host strobes.
module i2c_rd_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam logic [6:0] OWN = 7'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl_low = 1'b0;
    logic       m_sda_low = 1'b0;
    logic       scl_line, sda_line;
    logic       dut_scl, dut_sda;
    logic       buf_we = 1'b0, rel = 1'b0, iclr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       bfull, rw, irq;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_line = ~(m_scl_low | dut_scl);
    assign sda_line = ~(m_sda_low | dut_sda);

    i2c_rd_slave u_dut (
        .clk (clk), .rst_n (rst_n), .scl_i (scl_line), .sda_i (sda_line),
        .scl_pull_o (dut_scl), .sda_pull_o (dut_sda), .own_addr_i (OWN),
        .buf_we_i (buf_we), .buf_wdata_i (wdata), .release_i (rel),
        .irq_clr_i (iclr), .buf_rdata_o (rdata), .buf_full_o (bfull),
        .rw_o (rw), .irq_o (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        int guard = 0;
        while (scl_line !== 1'b1 && guard < 5000) begin
            tick(1);
            guard++;
        end
    endtask

    task automatic clock_bit(input logic drive_low, output logic smp, output logic stab);
        logic first;
        m_sda_low = drive_low;
        tick(HALF);
        m_scl_low = 1'b0;
        wait_scl_high();
        first = sda_line;
        tick(HALF);
        smp  = sda_line;
        stab = (first == smp);
        m_scl_low = 1'b1;
        tick(HALF);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; m_scl_low = 1'b0;
        tick(HALF);
        m_sda_low = 1'b1;
        tick(HALF);
        m_scl_low = 1'b1;
        tick(HALF);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1;
        tick(HALF);
        m_scl_low = 1'b0;
        wait_scl_high();
        tick(HALF);
        m_sda_low = 1'b0;
        tick(HALF);
    endtask

    task automatic send_addr(input logic [7:0] b, output logic ack_line);
        logic s, st;
        for (int i = 7; i >= 0; i--) clock_bit(~b[i], s, st);
        clock_bit(1'b0, ack_line, st);
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] v, output logic stab);
        logic s, st;
        stab = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b0, s, st);
            v[i] = s;
            stab &= st;
        end
        clock_bit(give_ack, s, st);
        m_sda_low = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] d);
        wdata = d; buf_we = 1'b1; tick(1); buf_we = 1'b0;
    endtask
    task automatic pulse_release();
        rel = 1'b1; tick(1); rel = 1'b0;
    endtask
    task automatic pulse_clear();
        iclr = 1'b1; tick(1); iclr = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        logic       ack_line, stab;
        logic [7:0] v;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R1: reset state
        chk("R1 scl pull", int'(dut_scl), 0);
        chk("R1 sda pull", int'(dut_sda), 0);
        chk("R1 flags", int'({bfull, rw, irq}), 0);
        chk("R1 buffer", int'(rdata), 0);

        // R6: write outside a stretch is ignored
        host_write(8'h3C);
        tick(2);
        chk("R6 idle write full", int'(bfull), 0);
        chk("R6 idle write buf", int'(rdata), 0);

        // R3: sweep every non-matching read address, then own address with write direction
        for (int a = 0; a < 129; a++) begin
            logic [7:0] ab;
            if (a == int'(OWN)) continue;
            ab = (a == 128) ? {OWN, 1'b0} : {a[6:0], 1'b1};
            bus_start();
            send_addr(ab, ack_line);
            chk("R3 no ack", int'(ack_line), 1);
            tick(2);
            chk("R3 no irq/rw/stretch", int'({irq, rw, dut_scl}), 0);
            bus_stop();
        end

        // R2/R4/R5/R6/R7/R8/R9: 16 transfers of 16 bytes cover all byte values
        for (int t = 0; t < 16; t++) begin
            bus_start();
            send_addr({OWN, 1'b1}, ack_line);
            chk("R2 ack", int'(ack_line), 0);
            chk("R2 rw", int'(rw), 1);
            chk("R2 buffer holds address", int'(rdata), int'({OWN, 1'b1}));
            chk("R4 irq after address", int'(irq), 1);
            m_scl_low = 1'b0;
            tick(20);
            chk("R5 scl stretched", int'(scl_line), 0);
            pulse_release();
            tick(4);
            chk("R5 release before write ignored", int'(scl_line), 0);
            chk("R4 irq held", int'(irq), 1);
            pulse_clear();
            chk("R4 irq cleared", int'(irq), 0);
            for (int k = 0; k < 16; k++) begin
                logic [7:0] d;
                d = 8'(t * 16 + k);
                host_write(d);
                chk("R6 full after write", int'(bfull), 1);
                chk("R6 buffer after write", int'(rdata), int'(d));
                pulse_release();
                read_byte(k != 15, v, stab);
                chk("R7 data", int'(v), int'(d));
                chk("R7 sda stable in high", int'(stab), 1);
                chk("R4 irq per byte", int'(irq), 1);
                chk("R8 full cleared", int'(bfull), 0);
                if (k != 15) begin
                    chk("R8 stretch after ack", int'(dut_scl), 1);
                end else begin
                    chk("R9 lines released", int'({dut_scl, dut_sda}), 0);
                    chk("R9 rw cleared", int'(rw), 0);
                end
                pulse_clear();
            end
            // R9: without a new Start nothing is served
            read_byte(1'b0, v, stab);
            chk("R9 no data after nack", int'(v), 8'hFF);
            chk("R9 no irq after nack", int'(irq), 0);
            bus_stop();
        end

        // R10: Stop in the middle of a data byte
        bus_start();
        send_addr({OWN, 1'b1}, ack_line);
        pulse_clear();
        host_write(8'hFF);
        pulse_release();
        for (int i = 0; i < 3; i++) clock_bit(1'b0, ack_line, stab);
        chk("R10 full before stop", int'(bfull), 1);
        bus_stop();
        tick(4);
        chk("R10 lines released", int'({dut_scl, dut_sda}), 0);
        chk("R10 full/rw cleared", int'({bfull, rw}), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule